// File: doc/BRIEF.md
# Peripheral Port and Interval Timer Controller

This block gives a processor three general-purpose I/O ports and a 14-bit interval timer behind a small register window. The CPU picks one of six registers with a 3-bit address and accesses it with single-cycle read and write strobes. Two byte-wide ports and one 6-bit port each hold an output value and a direction setting. A port read returns the driven value on output bits and the pin value on input bits.

The timer counts down from a programmed length and produces a waveform on `tmr_out`. The waveform is either a square wave or a one-cycle low pulse at terminal count. It can run once or repeat. A command field in the control register starts the timer, stops it at once, or stops it at the next terminal count. A start given while the timer runs is held back until the current period ends. A status flag records that terminal count was reached, and reading the status register clears it.

Top module: `pio_timer_ctrl`

## Requirements
- R1: Address 0 selects control (write) and status (read), 1 port A, 2 port B, 3 port C, 4 timer length low byte, 5 timer high byte. Reads of addresses 6 and 7 return zero, and writes to them change nothing.
- R2: A control write sets the port directions. Bit 0 high makes port A an output and bit 1 high makes port B an output. Bits 3:2 set port C: 00 all inputs, 01 bits 2:0 outputs, 10 bits 5:3 outputs, 11 all outputs. A port read returns the written value on output bits and the pin value on input bits. Port C reads put zero in bits 7:6.
- R3: After a synchronous active-low reset, every port is an input and every output value is zero. The timer is stopped, `tmr_out` is high and the status flag is clear.
- R4: Control bits 7:6 carry a timer command: 00 none, 01 stop at once, 10 stop at the next terminal count, 11 start. On a stop at once the count stays at the value reached on that edge. Commands 01 and 10 have no effect on an idle timer.
- R5: A start on an idle timer loads length N and the mode. The count holds N in the cycle after the write edge and drops by one each cycle. Terminal count is the cycle in which it holds 1. A repeating mode reloads N, so the period is N cycles.
- R6: A start while the timer runs takes the current length and mode registers at the next terminal count. The new period begins on the edge that ends the old one.
- R7: Bits 7:6 of the timer high byte select the mode: 00 single square, 01 repeating square, 10 single pulse, 11 repeating pulse. In square modes the output is high for the first ceil(N/2) cycles of a period and low for the rest. In pulse modes the output is low only in the terminal-count cycle. A single mode stops after its first period.
- R8: While the timer is stopped, `tmr_out` is high.
- R9: A programmed length below 2 behaves as a length of 2.
- R10: Status bit 6 is set on the edge that ends each terminal-count cycle and cleared by a status read. If both happen on the same edge, the flag ends up set.
- R11: Reading address 4 returns the low byte of the current count. Reading address 5 returns the active mode in bits 7:6 and count bits 13:8 in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe; a status read clears the flag |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A driven value |
| pa_oe | output | 1 | Port A drives its pins |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B driven value |
| pb_oe | output | 1 | Port B drives its pins |
| pc_in | input | 6 | Port C pin values |
| pc_out | output | 6 | Port C driven value |
| pc_oe | output | 6 | Port C per-bit drive enable |
| tmr_out | output | 1 | Timer waveform |

## Verification
The assertions assume `rst_n` is a clean synchronous reset and that a single strobe addresses one register per cycle. They also assume a stop-now command never lands on the terminal-count edge, where reload and freeze would compete. The stimulus issues one register access per cycle through tasks. Before each fresh start it stops the timer, so a start command always sees the intended idle or running state. Random lengths stay in the range 2 to 31 and random modes cover all four encodings. Directed cases place the reload, deferred stop and status read at computed cycle offsets from the start edge.

// File: rtl/pio_tmr_pkg.sv
`timescale 1ns/1ps
// Package: shared register-select codes, timer commands and timer modes.
// Assumes a 3-bit register select at the block edge.
package pio_tmr_pkg;
    typedef logic [2:0] rsel_t;
    localparam rsel_t RSEL_CTRL = 3'd0;
    localparam rsel_t RSEL_PA   = 3'd1;
    localparam rsel_t RSEL_PB   = 3'd2;
    localparam rsel_t RSEL_PC   = 3'd3;
    localparam rsel_t RSEL_TLO  = 3'd4;
    localparam rsel_t RSEL_THI  = 3'd5;

    typedef enum logic [1:0] {
        TCMD_NOP     = 2'b00,
        TCMD_HALT    = 2'b01,
        TCMD_HALT_TC = 2'b10,
        TCMD_GO      = 2'b11
    } tcmd_e;

    // bit 0 set = repeating, bit 1 set = pulse shape
    typedef enum logic [1:0] {
        TMODE_SQ_ONCE = 2'b00,
        TMODE_SQ_LOOP = 2'b01,
        TMODE_PL_ONCE = 2'b10,
        TMODE_PL_LOOP = 2'b11
    } tmode_e;
endpackage

// File: rtl/pio_port_reg.sv
`timescale 1ns/1ps
// Module: one I/O port register of parameterised width.
// Holds the driven value, and merges it with the pin inputs for reads
// using a per-bit drive enable supplied by the control logic.
// Assumes the write strobe is already qualified by the address decode.
module pio_port_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] oe,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] drv,
    output logic [W-1:0] rd_val
);
    // Capture the value written for the port's outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)      drv <= '0;
        else if (wr_stb) drv <= wr_val;
    end

    // Read view: driven value on output bits, pin value on input bits.
    always_comb rd_val = (drv & oe) | (pin_in & ~oe);
endmodule

// File: rtl/pio_timer_core.sv
`timescale 1ns/1ps
// Module: down-counting interval timer with deferred commands.
// Counts from the active length to 1, the terminal-count cycle, then reloads
// the length or ends the run. Stop-after-terminal-count and restart while
// running are held as pending flags that act on the terminal-count edge.
// Assumes at most one command strobe per cycle.
module pio_timer_core
    import pio_tmr_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_val,
    input  logic [1:0]       load_mode,
    input  logic             cmd_stb,
    input  tcmd_e            cmd,
    output logic [CNT_W-1:0] cnt_o,
    output logic [1:0]       mode_o,
    output logic             tc_o,
    output logic             wave_o
);
    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic             running, halt_pend, reload_pend;
    logic [CNT_W-1:0] cnt, cur_len, eff_len;
    logic [1:0]       cur_mode;
    logic             at_tc, end_run, run_after;

    // Clamp the programmed length and decide what this edge does to the run.
    always_comb begin
        eff_len   = (load_val < MIN_LEN) ? MIN_LEN : load_val;
        at_tc     = running && (cnt == ONE);
        end_run   = at_tc && (halt_pend || (!cur_mode[0] && !reload_pend));
        run_after = running && !end_run;
    end

    // Count, reload at terminal count, then apply any command on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running     <= 1'b0;
            halt_pend   <= 1'b0;
            reload_pend <= 1'b0;
            cnt         <= '0;
            cur_len     <= MIN_LEN;
            cur_mode    <= 2'b00;
        end else begin
            if (running) begin
                if (!at_tc) begin
                    cnt <= cnt - ONE;
                end else if (end_run) begin
                    running     <= 1'b0;
                    halt_pend   <= 1'b0;
                    reload_pend <= 1'b0;
                    cnt         <= cur_len;
                end else if (reload_pend) begin
                    cnt         <= eff_len;
                    cur_len     <= eff_len;
                    cur_mode    <= load_mode;
                    reload_pend <= 1'b0;
                end else begin
                    cnt <= cur_len;
                end
            end
            if (cmd_stb) begin
                case (cmd)
                    TCMD_HALT: if (run_after) begin
                        running     <= 1'b0;
                        halt_pend   <= 1'b0;
                        reload_pend <= 1'b0;
                    end
                    TCMD_HALT_TC: if (run_after) begin
                        halt_pend   <= 1'b1;
                        reload_pend <= 1'b0;
                    end
                    TCMD_GO: if (run_after) begin
                        reload_pend <= 1'b1;
                        halt_pend   <= 1'b0;
                    end else begin
                        running     <= 1'b1;
                        cnt         <= eff_len;
                        cur_len     <= eff_len;
                        cur_mode    <= load_mode;
                        halt_pend   <= 1'b0;
                        reload_pend <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output shape: high when idle, square by half-period, or low pulse at terminal count.
    always_comb wave_o = !running ||
                         (cur_mode[1] ? (cnt != ONE) : (cnt > (cur_len >> 1)));

    assign cnt_o  = cnt;
    assign mode_o = cur_mode;
    assign tc_o   = at_tc;

    // R5: a running count above 1 steps down by exactly one
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

    // R7: a single mode ends after its terminal count unless a restart is queued or issued
    a_r7_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (at_tc && !cur_mode[0] && !reload_pend && !(cmd_stb && cmd == TCMD_GO))
        |=> !running);

    // R4: a stop-now command leaves the timer idle
    a_r4_halt_now: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd == TCMD_HALT) |=> !running);

    // R9: a running timer never has a length below 2 or a count outside 1..length
    a_r9_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cur_len >= MIN_LEN && cnt >= ONE && cnt <= cur_len));

    // R8: the waveform is high after any edge that leaves the timer idle
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd == TCMD_HALT) |=> wave_o);
endmodule

// File: rtl/pio_timer_ctrl.sv
`timescale 1ns/1ps
// Module: top of the port and timer controller.
// Decodes the register window, holds port direction and timer length/mode
// registers, keeps the terminal-count status flag and muxes read data.
// Assumes one register access per cycle and single-cycle strobes.
module pio_timer_ctrl
    import pio_tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 14,
    parameter int PC_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [PC_W-1:0]   pc_in,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   pc_oe,
    output logic              tmr_out
);
    localparam int HI_W     = CNT_W - DATA_W;
    localparam int MODE_W   = 2 * DATA_W - CNT_W;
    localparam int PC_HALF  = PC_W / 2;
    localparam int FLAG_BIT = 6;

    logic              dir_a, dir_b, tc_flag;
    logic [1:0]        pc_sel;
    logic [DATA_W-1:0] len_lo;
    logic [HI_W-1:0]   len_hi;
    logic [MODE_W-1:0] len_mode;
    logic [DATA_W-1:0] pa_rd, pb_rd;
    logic [PC_W-1:0]   pc_rd;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        mode_act;
    logic              tc, wave, cmd_stb;
    tcmd_e             cmd;

    // Decode the command strobe and field.
    always_comb begin
        cmd_stb = wr_en && (addr == RSEL_CTRL);
        cmd     = tcmd_e'(wdata[DATA_W-1 -: 2]);
    end

    // Control and timer length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_a    <= 1'b0;
            dir_b    <= 1'b0;
            pc_sel   <= 2'b00;
            len_lo   <= '0;
            len_hi   <= '0;
            len_mode <= '0;
        end else if (wr_en) begin
            case (addr)
                RSEL_CTRL: begin
                    dir_a  <= wdata[0];
                    dir_b  <= wdata[1];
                    pc_sel <= wdata[3:2];
                end
                RSEL_TLO: len_lo <= wdata;
                RSEL_THI: begin
                    len_hi   <= wdata[HI_W-1:0];
                    len_mode <= wdata[DATA_W-1:HI_W];
                end
                default: ;
            endcase
        end
    end

    // Port C drive enables: lower half follows select bit 0, upper half bit 1.
    generate
        for (genvar i = 0; i < PC_W; i++) begin : g_pc_oe
            if (i < PC_HALF) begin : g_lo
                assign pc_oe[i] = pc_sel[0];
            end else begin : g_hi
                assign pc_oe[i] = pc_sel[1];
            end
        end
    endgenerate

    assign pa_oe = dir_a;
    assign pb_oe = dir_b;

    pio_port_reg #(.W(DATA_W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_en && addr == RSEL_PA),
        .wr_val(wdata), .oe({DATA_W{dir_a}}), .pin_in(pa_in),
        .drv(pa_out), .rd_val(pa_rd));

    pio_port_reg #(.W(DATA_W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_en && addr == RSEL_PB),
        .wr_val(wdata), .oe({DATA_W{dir_b}}), .pin_in(pb_in),
        .drv(pb_out), .rd_val(pb_rd));

    pio_port_reg #(.W(PC_W)) u_port_c (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_en && addr == RSEL_PC),
        .wr_val(wdata[PC_W-1:0]), .oe(pc_oe), .pin_in(pc_in),
        .drv(pc_out), .rd_val(pc_rd));

    pio_timer_core #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_val({len_hi, len_lo}),
        .load_mode(len_mode), .cmd_stb(cmd_stb), .cmd(cmd),
        .cnt_o(cnt), .mode_o(mode_act), .tc_o(tc), .wave_o(wave));

    assign tmr_out = wave;

    // Status flag: set on terminal count, cleared by a status read; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                            tc_flag <= 1'b0;
        else if (tc)                           tc_flag <= 1'b1;
        else if (rd_en && addr == RSEL_CTRL)   tc_flag <= 1'b0;
    end

    // Read data mux for the selected register.
    always_comb begin
        rdata = '0;
        case (addr)
            RSEL_CTRL: rdata[FLAG_BIT] = tc_flag;
            RSEL_PA:   rdata = pa_rd;
            RSEL_PB:   rdata = pb_rd;
            RSEL_PC:   rdata[PC_W-1:0] = pc_rd;
            RSEL_TLO:  rdata = cnt[DATA_W-1:0];
            RSEL_THI:  rdata = {mode_act, cnt[CNT_W-1:DATA_W]};
            default:   rdata = '0;
        endcase
    end

    // R10: terminal count always leaves the flag set on the next cycle
    a_r10_flag_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> tc_flag);

    // R10: with no terminal count, a status read leaves the flag clear
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RSEL_CTRL && !tc) |=> !tc_flag);

    // R1: a write to an unmapped address leaves the port directions unchanged
    a_r1_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > RSEL_THI) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
endmodule

// File: tb/pio_timer_ctrl_tb.sv
`timescale 1ns/100ps
module pio_timer_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] addr;
    logic       wr_en, rd_en;
    logic [7:0] wdata, rdata;
    logic [7:0] pa_in, pa_out, pb_in, pb_out;
    logic       pa_oe, pb_oe;
    logic [5:0] pc_in, pc_out, pc_oe;
    logic       tmr_out;

    int n_chk = 0;
    int n_bad = 0;
    int unsigned cyc = 0;
    int e0 = 0;
    logic [5:0] ctrl_lo = 6'd0;
    localparam int BIG = 1 << 30;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pio_timer_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .tmr_out(tmr_out));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1; d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // Expected waveform j cycles after the start edge (R5, R7, R9)
    function automatic int exp_wave(input int mode, input int n0, input int j);
        int n;
        int p;
        n = (n0 < 2) ? 2 : n0;
        if ((mode % 2) == 0 && j >= n) return 1;
        p = j % n;
        if (mode >= 2) return (p != n - 1) ? 1 : 0;
        return (p < (n + 1) / 2) ? 1 : 0;
    endfunction

    task automatic start(input int n, input int mode);
        logic [13:0] nv;
        nv = 14'(n);
        wr(3'd4, nv[7:0]);
        wr(3'd5, {2'(mode), nv[13:8]});
        wr(3'd0, {2'b11, ctrl_lo});
        e0 = int'(cyc);
    endtask

    task automatic halt();
        wr(3'd0, {2'b01, ctrl_lo});
    endtask

    // Check tmr_out every cycle up to to_j; first segment then second; high after stop_j
    task automatic watch(input string tag, input int m1, input int n1,
                         input int m2, input int n2, input int sw_j,
                         input int stop_j, input int to_j);
        while (int'(cyc) - e0 <= to_j) begin
            int j;
            int e;
            j = int'(cyc) - e0;
            if (j >= stop_j)    e = 1;
            else if (j < sw_j)  e = exp_wave(m1, n1, j);
            else                e = exp_wave(m2, n2, j - sw_j);
            chk(tag, int'(tmr_out), e);
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 6'h2D;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        chk("R3 pa_oe", pa_oe, 0);
        chk("R3 pb_oe", pb_oe, 0);
        chk("R3 pc_oe", pc_oe, 0);
        chk("R3 pa_out", pa_out, 0);
        chk("R3 tmr_out", tmr_out, 1);
        rd(3'd0, d); chk("R3 status", d, 8'h00);
        rd(3'd1, d); chk("R3 port A reads pins", d, 8'h5A);

        // R2 random port patterns
        for (int k = 0; k < 20; k++) begin
            logic [7:0] va, vb;
            logic [5:0] vc, oe_c;
            logic [1:0] sel;
            logic da, db;
            da = 1'($urandom); db = 1'($urandom); sel = 2'($urandom);
            va = 8'($urandom); vb = 8'($urandom); vc = 6'($urandom);
            ctrl_lo = {2'b00, sel, db, da};
            wr(3'd0, {2'b00, ctrl_lo});
            wr(3'd1, va); wr(3'd2, vb); wr(3'd3, {2'b00, vc});
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 6'($urandom);
            oe_c = {{3{sel[1]}}, {3{sel[0]}}};
            chk("R2 pa_oe", pa_oe, da);
            chk("R2 pb_oe", pb_oe, db);
            chk("R2 pc_oe", pc_oe, oe_c);
            chk("R2 pa_out", pa_out, va);
            rd(3'd1, d); chk("R2 port A read", d, da ? va : pa_in);
            rd(3'd2, d); chk("R2 port B read", d, db ? vb : pb_in);
            rd(3'd3, d); chk("R2 port C read", d, {2'b00, (vc & oe_c) | (pc_in & ~oe_c)});
        end

        // R1 unmapped addresses
        ctrl_lo = 6'b00_11_11;
        wr(3'd0, {2'b00, ctrl_lo});
        wr(3'd1, 8'hA5);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'h00);
        rd(3'd6, d); chk("R1 read addr 6", d, 0);
        rd(3'd7, d); chk("R1 read addr 7", d, 0);
        rd(3'd1, d); chk("R1 port A untouched", d, 8'hA5);
        chk("R1 dirs untouched", {pa_oe, pb_oe, pc_oe}, 8'hFF);

        // R4 commands on idle timer are ignored; R8 idle high
        wr(3'd0, {2'b10, ctrl_lo});
        wr(3'd0, {2'b01, ctrl_lo});
        chk("R8 idle output", tmr_out, 1);
        start(4, 1);
        watch("R4 idle stop-at-tc ignored", 1, 4, 0, 0, BIG, BIG, 16);
        halt();

        // R7 square and pulse, odd length
        start(7, 1);
        watch("R7 repeating square odd", 1, 7, 0, 0, BIG, BIG, 22);
        halt();
        start(5, 3);
        watch("R7 repeating pulse", 3, 5, 0, 0, BIG, BIG, 16);
        halt();

        // R9 lengths below 2
        start(1, 1);
        watch("R9 length 1 acts as 2", 1, 2, 0, 0, BIG, BIG, 8);
        halt();
        start(0, 3);
        watch("R9 length 0 acts as 2", 3, 2, 0, 0, BIG, BIG, 8);
        halt();

        // R6 restart while running loads at next terminal count
        start(20, 1);
        watch("R6 before reload", 1, 20, 0, 0, BIG, BIG, 3);
        wr(3'd4, 8'd4);
        wr(3'd5, {2'b11, 6'd0});
        wr(3'd0, {2'b11, ctrl_lo});
        watch("R6 reload at terminal count", 1, 20, 3, 4, 20, BIG, 36);
        halt();

        // R4 stop after terminal count
        start(10, 1);
        wr(3'd0, {2'b10, ctrl_lo});
        watch("R4 stop after terminal count", 1, 10, 0, 0, BIG, 10, 30);

        // R4 stop now freezes count; R11 readback
        start(50, 1);
        repeat (5) @(negedge clk);
        wr(3'd0, {2'b01, ctrl_lo});
        begin
            int js;
            js = int'(cyc) - e0;
            repeat (3) @(negedge clk);
            chk("R4 stop now output high", tmr_out, 1);
            rd(3'd4, d); chk("R11 frozen count low", d, 50 - js);
            rd(3'd5, d); chk("R11 mode and count high", d, 8'h40);
        end
        start(14'h2A05, 1);
        rd(3'd5, d); chk("R11 high byte readback", d, 8'h6A);
        halt();

        // R10 read in the terminal-count cycle: set wins
        rd(3'd0, d);
        start(8, 2);
        while (int'(cyc) - e0 < 6) @(negedge clk);
        rd(3'd0, d); chk("R10 flag before terminal count", d, 8'h00);
        rd(3'd0, d); chk("R10 set wins over read clear", d, 8'h40);
        rd(3'd0, d); chk("R10 read clears flag", d, 8'h00);
        chk("R7 single pulse ended high", tmr_out, 1);

        // R5 R7 random lengths and modes
        for (int k = 0; k < 24; k++) begin
            int n, m;
            n = 2 + int'($urandom % 30);
            m = int'($urandom % 4);
            halt();
            rd(3'd0, d);
            start(n, m);
            watch("R5 R7 random run", m, n, 0, 0, BIG, BIG, 2 * n + 3);
            rd(3'd0, d); chk("R10 flag after run", d, 8'h40);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule